// File: doc/BRIEF.md
# Video Processor CPU Register Interface

This block is the processor-facing register window of a tile-based video engine. A host reaches it through eight byte-wide addresses on a simple synchronous strobe bus. The window holds the control and mask bytes and a three-bit status field. It also holds a pointer into sprite attribute memory and a 15-bit staging address that gathers scroll and address bytes. Alongside these are the 15-bit live video-memory address, a three-bit fine horizontal scroll value and a single toggle shared by the scroll and address ports to tell first bytes from second bytes.

The data port moves bytes between the host and video memory. Below the palette page, writes appear as strobes on a video-memory bus and reads pass through a one-byte read-ahead buffer. Inside the palette page (live address bits [13:8] equal to 0x3F), bytes go to and come from a 32-entry palette store with no buffering. The live address steps after every data-port access. A rendering engine outside this block drives flag inputs that set or clear the status bits, and it reads the control, mask, scroll and address state from dedicated outputs.

Register map (bus_addr): 0 control (write), 1 mask (write), 2 status (read), 3 sprite pointer (write), 4 sprite data (read/write), 5 scroll (write, two bytes), 6 address (write, two bytes), 7 data (read/write).

Top module: `vid_regs_if`

## Requirements
- R1: After reset, control, mask, staging address, live address, fine scroll, toggle, status, the bus latch, the sprite pointer and the read buffer are all zero, so a status read returns 0x00.
- R2: A control write stores the byte on ctrl_o and copies data[1:0] into staging bits [11:10], leaving the other staging bits unchanged.
- R3: With the toggle clear, a scroll write puts data[2:0] in fine scroll and data[7:3] in staging bits [4:0], then sets the toggle. With the toggle set, it puts data[2:0] in staging bits [14:12] and data[7:3] in staging bits [9:5], then clears the toggle.
- R4: With the toggle clear, an address write puts data[5:0] in staging bits [13:8], zeroes staging bit 14 and sets the toggle. With the toggle set, it puts the byte in staging bits [7:0], loads the whole staging value into the live address, and clears the toggle.
- R5: A status read returns {vblank, hit, overflow, latch[4:0]} with vblank in bit 7, hit in bit 6 and overflow in bit 5. The read then clears vblank and the toggle.
- R6: Every data-port access, read or write, adds 32 to the live address when control bit 2 is 1 and adds 1 otherwise, modulo 2^15.
- R7: A data-port read outside the palette page returns the buffered byte, raises vmem_rd with vmem_addr equal to live address [13:0], and reloads the buffer from vmem_rdata.
- R8: A data-port write outside the palette page raises vmem_wr with vmem_addr equal to live address [13:0] and vmem_wdata equal to the byte. Inside the palette page it writes the palette store and raises neither strobe.
- R9: The palette index is live address [4:0] with bit 4 forced to 0 whenever bits [1:0] are 00. This rule applies to both reads and writes. Palette reads return the stored byte in the same access.
- R10: A sprite-data write stores the byte at the sprite pointer and then increments the pointer modulo the memory depth. A sprite-data read returns the byte at the pointer and leaves the pointer unchanged.
- R11: A read of a write-only address (0, 1, 3, 5, 6) returns the bus latch. The latch takes every written byte and every value returned by a read.
- R12: rnd_vbl_set, rnd_hit_set and rnd_ovf_set set status bits 7, 6 and 5. rnd_frame_clr clears all three and is applied before the sets in the same cycle. A status read in the same cycle overrides any set of bit 7, so bit 7 ends up 0.
- R13: A mask write stores the byte on mask_o without touching any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of a read strobe |
| vmem_addr | output | 14 | Video-memory address (live address [13:0]) |
| vmem_rd | output | 1 | Video-memory read strobe |
| vmem_wr | output | 1 | Video-memory write strobe |
| vmem_wdata | output | 8 | Video-memory write byte |
| vmem_rdata | input | 8 | Video-memory read byte, same cycle as vmem_rd |
| rnd_vbl_set | input | 1 | Set status bit 7 |
| rnd_hit_set | input | 1 | Set status bit 6 |
| rnd_ovf_set | input | 1 | Set status bit 5 |
| rnd_frame_clr | input | 1 | Clear status bits 7..5 |
| ctrl_o | output | 8 | Control byte |
| mask_o | output | 8 | Mask byte |
| fine_x_o | output | 3 | Fine horizontal scroll |
| tmp_addr_o | output | 15 | Staging address |
| cur_addr_o | output | 15 | Live video-memory address |

## Verification
The bench builds the block with its default parameters: a 256-byte sprite memory, a 32-entry palette and a row step of 32. With these values it fills the whole sprite memory and the whole palette, so the sprite pointer wraps from 255 to 0 and every palette index, folded or not, is written before any read. Address writes steer the live address into the palette page half of the time. Random accesses then reach both address steps, both toggle phases, status reads that collide with flag sets, and buffered reads against a video memory whose contents are computed from the address.

// File: rtl/vri_pkg.sv
package vri_pkg;
  localparam logic [2:0] RG_CTRL = 3'd0;
  localparam logic [2:0] RG_MASK = 3'd1;
  localparam logic [2:0] RG_STAT = 3'd2;
  localparam logic [2:0] RG_SPA  = 3'd3;
  localparam logic [2:0] RG_SPD  = 3'd4;
  localparam logic [2:0] RG_SCRL = 3'd5;
  localparam logic [2:0] RG_ADDR = 3'd6;
  localparam logic [2:0] RG_DATA = 3'd7;
  localparam int         VA_W     = 15;
  localparam logic [5:0] PAL_PAGE = 6'h3F;

  // Entries whose low two bits are zero share storage across the two halves.
  function automatic logic [4:0] pal_fold(input logic [4:0] idx);
    logic [4:0] r;
    r = idx;
    if (idx[1:0] == 2'b00) r[4] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/vri_ram.sv
module vri_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/vri_addr_unit.sv
module vri_addr_unit
  import vri_pkg::*;
#(
  parameter int ROW_STEP = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_ctrl,
  input  logic            wr_scroll,
  input  logic            wr_addr,
  input  logic            clr_toggle,
  input  logic            data_acc,
  input  logic            big_step,
  input  logic [7:0]      wdata,
  output logic [VA_W-1:0] tmp_q,
  output logic [VA_W-1:0] cur_q,
  output logic [2:0]      fx_q,
  output logic            tg_q
);
  localparam logic [VA_W-1:0] STEP_HI = VA_W'(ROW_STEP);
  localparam logic [VA_W-1:0] STEP_LO = VA_W'(1);

  logic [VA_W-1:0] tmp_n, cur_n;
  logic [2:0]      fx_n;
  logic            tg_n;
  logic            en;

  assign en = wr_ctrl | wr_scroll | wr_addr | clr_toggle | data_acc;

  always_comb begin
    tmp_n = tmp_q;
    cur_n = cur_q;
    fx_n  = fx_q;
    tg_n  = tg_q;
    if (wr_ctrl) tmp_n[11:10] = wdata[1:0];
    if (wr_scroll) begin
      if (!tg_q) begin
        fx_n       = wdata[2:0];
        tmp_n[4:0] = wdata[7:3];
        tg_n       = 1'b1;
      end else begin
        tmp_n[14:12] = wdata[2:0];
        tmp_n[9:5]   = wdata[7:3];
        tg_n         = 1'b0;
      end
    end
    if (wr_addr) begin
      if (!tg_q) begin
        tmp_n[13:8] = wdata[5:0];
        tmp_n[14]   = 1'b0;
        tg_n        = 1'b1;
      end else begin
        tmp_n[7:0] = wdata;
        cur_n      = {tmp_q[14:8], wdata};
        tg_n       = 1'b0;
      end
    end
    if (data_acc) cur_n = cur_q + (big_step ? STEP_HI : STEP_LO);
    if (clr_toggle) tg_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q <= '0;
      cur_q <= '0;
      fx_q  <= '0;
      tg_q  <= 1'b0;
    end else if (en) begin
      tmp_q <= tmp_n;
      cur_q <= cur_n;
      fx_q  <= fx_n;
      tg_q  <= tg_n;
    end
  end

  p_toggle_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_scroll || wr_addr) |=> (tg_q != $past(tg_q)));
  p_addr_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr && tg_q) |=> (cur_q == tmp_q));
  p_toggle_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_toggle |=> !tg_q);
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !big_step) |=> (cur_q == $past(cur_q) + STEP_LO));
endmodule

// File: rtl/vri_status.sv
module vri_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_status,
  input  logic       set_vbl,
  input  logic       set_hit,
  input  logic       set_ovf,
  input  logic       clr_all,
  output logic [2:0] st_q
);
  logic [2:0] st_n;
  logic       en;

  assign en = rd_status | set_vbl | set_hit | set_ovf | clr_all;

  always_comb begin
    st_n = st_q;
    if (clr_all) st_n = '0;
    if (set_vbl) st_n[2] = 1'b1;
    if (set_hit) st_n[1] = 1'b1;
    if (set_ovf) st_n[0] = 1'b1;
    if (rd_status) st_n[2] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else if (en) st_q <= st_n;
  end

  p_read_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |=> !st_q[2]);
  p_hit_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    set_hit |=> st_q[1]);
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !set_vbl && !set_hit && !set_ovf) |=> (st_q == 3'b000));
endmodule

// File: rtl/vid_regs_if.sv
module vid_regs_if
  import vri_pkg::*;
#(
  parameter int SPR_DEPTH = 256,
  parameter int PAL_DEPTH = 32,
  parameter int ROW_STEP  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic [13:0]     vmem_addr,
  output logic            vmem_rd,
  output logic            vmem_wr,
  output logic [7:0]      vmem_wdata,
  input  logic [7:0]      vmem_rdata,
  input  logic            rnd_vbl_set,
  input  logic            rnd_hit_set,
  input  logic            rnd_ovf_set,
  input  logic            rnd_frame_clr,
  output logic [7:0]      ctrl_o,
  output logic [7:0]      mask_o,
  output logic [2:0]      fine_x_o,
  output logic [VA_W-1:0] tmp_addr_o,
  output logic [VA_W-1:0] cur_addr_o
);
  localparam int SPR_AW = $clog2(SPR_DEPTH);
  localparam int PAL_AW = $clog2(PAL_DEPTH);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // access decode
  logic [7:0] wsel, rsel, asel;
  for (genvar k = 0; k < 8; k++) begin : g_dec
    assign asel[k] = bus_sel && (bus_addr == 3'(k));
    assign wsel[k] = asel[k] && bus_we;
    assign rsel[k] = asel[k] && !bus_we;
  end

  logic [7:0]        ctrl_q, mask_q, ob_q, rbuf_q;
  logic [7:0]        ctrl_n, mask_n, ob_n, rbuf_n;
  logic [SPR_AW-1:0] spa_q, spa_n;
  logic [2:0]        st_q;
  logic [VA_W-1:0]   tmp_q, cur_q;
  logic [2:0]        fx_q;
  logic              tg_q;
  logic              pal_sel;
  logic [7:0]        spr_rd, pal_rd;
  logic [PAL_AW-1:0] pal_idx;

  assign pal_sel = (cur_q[13:8] == PAL_PAGE);
  assign pal_idx = PAL_AW'(pal_fold(cur_q[4:0]));

  vri_addr_unit #(.ROW_STEP(ROW_STEP)) u_addr (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_ctrl    (wsel[RG_CTRL]),
    .wr_scroll  (wsel[RG_SCRL]),
    .wr_addr    (wsel[RG_ADDR]),
    .clr_toggle (rsel[RG_STAT]),
    .data_acc   (asel[RG_DATA]),
    .big_step   (ctrl_q[2]),
    .wdata      (bus_wdata),
    .tmp_q      (tmp_q),
    .cur_q      (cur_q),
    .fx_q       (fx_q),
    .tg_q       (tg_q)
  );

  vri_status u_stat (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .rd_status (rsel[RG_STAT]),
    .set_vbl   (rnd_vbl_set),
    .set_hit   (rnd_hit_set),
    .set_ovf   (rnd_ovf_set),
    .clr_all   (rnd_frame_clr),
    .st_q      (st_q)
  );

  vri_ram #(.DEPTH(SPR_DEPTH), .W(8)) u_spr (
    .clk   (clk),
    .we    (wsel[RG_SPD]),
    .addr  (spa_q),
    .wdata (bus_wdata),
    .rdata (spr_rd)
  );

  vri_ram #(.DEPTH(PAL_DEPTH), .W(8)) u_pal (
    .clk   (clk),
    .we    (wsel[RG_DATA] && pal_sel),
    .addr  (pal_idx),
    .wdata (bus_wdata),
    .rdata (pal_rd)
  );

  // read mux
  always_comb begin
    case (bus_addr)
      RG_STAT: bus_rdata = {st_q, ob_q[4:0]};
      RG_SPD:  bus_rdata = spr_rd;
      RG_DATA: bus_rdata = pal_sel ? pal_rd : rbuf_q;
      default: bus_rdata = ob_q;
    endcase
  end

  assign vmem_addr  = cur_q[13:0];
  assign vmem_wdata = bus_wdata;
  assign vmem_rd    = rsel[RG_DATA] && !pal_sel;
  assign vmem_wr    = wsel[RG_DATA] && !pal_sel;

  // next state of local registers
  always_comb begin
    ctrl_n = ctrl_q;
    mask_n = mask_q;
    spa_n  = spa_q;
    ob_n   = ob_q;
    rbuf_n = rbuf_q;
    if (wsel[RG_CTRL]) ctrl_n = bus_wdata;
    if (wsel[RG_MASK]) mask_n = bus_wdata;
    if (wsel[RG_SPA])  spa_n  = bus_wdata[SPR_AW-1:0];
    if (wsel[RG_SPD])  spa_n  = spa_q + 1'b1;
    if (bus_sel)       ob_n   = bus_we ? bus_wdata : bus_rdata;
    if (vmem_rd)       rbuf_n = vmem_rdata;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      spa_q  <= '0;
      ob_q   <= '0;
      rbuf_q <= '0;
    end else if (bus_sel) begin
      ctrl_q <= ctrl_n;
      mask_q <= mask_n;
      spa_q  <= spa_n;
      ob_q   <= ob_n;
      rbuf_q <= rbuf_n;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign mask_o     = mask_q;
  assign fine_x_o   = fx_q;
  assign tmp_addr_o = tmp_q;
  assign cur_addr_o = cur_q;

  p_spr_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsel[RG_SPD] |=> $stable(spa_q));
  p_spr_write_step_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    wsel[RG_SPD] |=> (spa_q == $past(spa_q) + 1'b1));
  p_latch_write_r11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_sel && bus_we) |=> (ob_q == $past(bus_wdata)));
  p_buf_refill_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    vmem_rd |=> (rbuf_q == $past(vmem_rdata)));
  p_pal_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (asel[RG_DATA] && pal_sel) |-> !(vmem_rd || vmem_wr));
endmodule

// File: tb/vid_regs_if_tb.sv
module vid_regs_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [13:0] vmem_addr;
  logic        vmem_rd, vmem_wr;
  logic [7:0]  vmem_wdata, vmem_rdata;
  logic        vbl = 1'b0, hit = 1'b0, ovf = 1'b0, fclr = 1'b0;
  logic [7:0]  ctrl_o, mask_o;
  logic [2:0]  fine_x_o;
  logic [14:0] tmp_addr_o, cur_addr_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_fn(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b11};
  endfunction
  assign vmem_rdata = mem_fn(vmem_addr);

  vid_regs_if u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vmem_addr(vmem_addr), .vmem_rd(vmem_rd), .vmem_wr(vmem_wr),
    .vmem_wdata(vmem_wdata), .vmem_rdata(vmem_rdata),
    .rnd_vbl_set(vbl), .rnd_hit_set(hit), .rnd_ovf_set(ovf),
    .rnd_frame_clr(fclr), .ctrl_o(ctrl_o), .mask_o(mask_o),
    .fine_x_o(fine_x_o), .tmp_addr_o(tmp_addr_o), .cur_addr_o(cur_addr_o)
  );

  // reference model state
  logic [7:0]  m_ctrl, m_mask, m_ob, m_rbuf, m_spa;
  logic [2:0]  m_st, m_fx;
  logic [14:0] m_tmp, m_cur;
  logic        m_tg;
  logic [7:0]  m_pal [32];
  logic [7:0]  m_spr [256];

  function automatic logic [4:0] fold(input logic [4:0] i);
    logic [4:0] r;
    r = i;
    if (i[1:0] == 2'b00) r[4] = 1'b0;
    return r;
  endfunction

  function automatic string req_of(input bit we, input logic [2:0] a);
    case (a)
      3'd0: return "R2";
      3'd1: return "R13";
      3'd2: return "R5";
      3'd3, 3'd4: return "R10";
      3'd5: return "R3";
      3'd6: return "R4";
      default: return we ? "R8" : "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(input bit we, input logic [2:0] a, input logic [7:0] d,
                    input logic [3:0] rnd);
    logic [7:0] exp_rd;
    bit         pal;
    string      rq;
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    {vbl, hit, ovf, fclr} = rnd;
    #2;
    pal = (m_cur[13:8] == 6'h3F);
    rq = req_of(we, a);
    if (!we) begin
      case (a)
        3'd2: exp_rd = {m_st, m_ob[4:0]};
        3'd4: exp_rd = m_spr[m_spa];
        3'd7: exp_rd = pal ? m_pal[fold(m_cur[4:0])] : m_rbuf;
        default: exp_rd = m_ob;
      endcase
      chk(bus_rdata == exp_rd,
          (a == 3'd7) ? (pal ? "R9" : "R7") : (a == 3'd2) ? "R5" : (a == 3'd4) ? "R10" : "R11",
          "read data", 32'(bus_rdata), 32'(exp_rd));
    end else exp_rd = 8'h00;
    chk(vmem_rd == (!we && a == 3'd7 && !pal), "R7", "vmem_rd", 32'(vmem_rd),
        32'(!we && a == 3'd7 && !pal));
    chk(vmem_wr == (we && a == 3'd7 && !pal), "R8", "vmem_wr", 32'(vmem_wr),
        32'(we && a == 3'd7 && !pal));
    if (a == 3'd7 && !pal)
      chk(vmem_addr == m_cur[13:0], "R8", "vmem_addr", 32'(vmem_addr), 32'(m_cur[13:0]));
    if (we && a == 3'd7 && !pal)
      chk(vmem_wdata == d, "R8", "vmem_wdata", 32'(vmem_wdata), 32'(d));
    // model update
    if (fclr) m_st = 3'b000;
    if (vbl) m_st[2] = 1'b1;
    if (hit) m_st[1] = 1'b1;
    if (ovf) m_st[0] = 1'b1;
    if (we) begin
      m_ob = d;
      case (a)
        3'd0: begin m_ctrl = d; m_tmp[11:10] = d[1:0]; end
        3'd1: m_mask = d;
        3'd3: m_spa = d;
        3'd4: begin m_spr[m_spa] = d; m_spa = m_spa + 8'd1; end
        3'd5: begin
          if (!m_tg) begin m_fx = d[2:0]; m_tmp[4:0] = d[7:3]; end
          else begin m_tmp[14:12] = d[2:0]; m_tmp[9:5] = d[7:3]; end
          m_tg = !m_tg;
        end
        3'd6: begin
          if (!m_tg) begin m_tmp[13:8] = d[5:0]; m_tmp[14] = 1'b0; end
          else begin m_tmp[7:0] = d; m_cur = m_tmp; end
          m_tg = !m_tg;
        end
        3'd7: begin
          if (pal) m_pal[fold(m_cur[4:0])] = d;
          m_cur = m_cur + (m_ctrl[2] ? 15'd32 : 15'd1);
        end
        default: ;
      endcase
    end else begin
      m_ob = exp_rd;
      if (a == 3'd2) begin m_st[2] = 1'b0; m_tg = 1'b0; end
      if (a == 3'd7) begin
        if (!pal) m_rbuf = mem_fn(m_cur[13:0]);
        m_cur = m_cur + (m_ctrl[2] ? 15'd32 : 15'd1);
      end
    end
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0; {vbl, hit, ovf, fclr} = 4'h0;
    chk(ctrl_o == m_ctrl, rq, "ctrl_o", 32'(ctrl_o), 32'(m_ctrl));
    chk(mask_o == m_mask, rq, "mask_o", 32'(mask_o), 32'(m_mask));
    chk(tmp_addr_o == m_tmp, rq, "tmp_addr_o", 32'(tmp_addr_o), 32'(m_tmp));
    chk(cur_addr_o == m_cur, rq, "cur_addr_o", 32'(cur_addr_o), 32'(m_cur));
    chk(fine_x_o == m_fx, rq, "fine_x_o", 32'(fine_x_o), 32'(m_fx));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_ctrl = 0; m_mask = 0; m_ob = 0; m_rbuf = 0; m_spa = 0;
    m_st = 0; m_fx = 0; m_tmp = 0; m_cur = 0; m_tg = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1: reset state
    #1;
    chk(ctrl_o == 0 && mask_o == 0 && fine_x_o == 0, "R1", "ctrl/mask/fx",
        {8'h0, ctrl_o, mask_o, 5'h0, fine_x_o}, 32'h0);
    chk(tmp_addr_o == 0 && cur_addr_o == 0, "R1", "addresses",
        {1'b0, tmp_addr_o, 1'b0, cur_addr_o}, 32'h0);
    op(1'b0, 3'd2, 8'h00, 4'h0);                   // R1 status reads 0x00
    // R2 control fills staging [11:10]
    op(1'b1, 3'd0, 8'hF3, 4'h0);
    op(1'b1, 3'd0, 8'h00, 4'h0);
    // R3 scroll pair, R5 toggle clear between halves
    op(1'b1, 3'd5, 8'hAD, 4'h0);
    op(1'b0, 3'd2, 8'h00, 4'h0);
    op(1'b1, 3'd5, 8'h6F, 4'h0);
    op(1'b1, 3'd5, 8'h5B, 4'h0);
    // R4 address pair into palette page; R9 fold on write then read
    op(1'b1, 3'd6, 8'hFF, 4'h0);
    op(1'b1, 3'd6, 8'h00, 4'h0);
    for (int i = 0; i < 32; i++) op(1'b1, 3'd7, 8'(8'h40 + i), 4'h0);
    op(1'b1, 3'd6, 8'h3F, 4'h0);
    op(1'b1, 3'd6, 8'h10, 4'h0);
    op(1'b0, 3'd7, 8'h00, 4'h0);                    // R9 0x10 reads entry 0
    op(1'b0, 3'd7, 8'h00, 4'h0);
    // R7 buffered read below palette page, R6 row step
    op(1'b1, 3'd0, 8'h04, 4'h0);
    op(1'b1, 3'd6, 8'h21, 4'h0);
    op(1'b1, 3'd6, 8'h08, 4'h0);
    op(1'b0, 3'd7, 8'h00, 4'h0);
    op(1'b0, 3'd7, 8'h00, 4'h0);
    op(1'b1, 3'd7, 8'h99, 4'h0);                    // R8 external write
    op(1'b1, 3'd0, 8'h00, 4'h0);
    // R10 sprite fill and pointer wrap
    op(1'b1, 3'd3, 8'h00, 4'h0);
    for (int i = 0; i < 256; i++) op(1'b1, 3'd4, 8'(i * 7 + 3), 4'h0);
    op(1'b0, 3'd4, 8'h00, 4'h0);
    op(1'b0, 3'd4, 8'h00, 4'h0);
    // R11 write-only reads
    op(1'b1, 3'd1, 8'h5A, 4'h0);
    op(1'b0, 3'd1, 8'h00, 4'h0);
    op(1'b0, 3'd6, 8'h00, 4'h0);
    // R12 flag inputs, clear, and read priority
    op(1'b0, 3'd0, 8'h00, 4'b1110);
    op(1'b0, 3'd2, 8'h00, 4'b1000);
    op(1'b0, 3'd2, 8'h00, 4'b0001);
    op(1'b0, 3'd2, 8'h00, 4'h0);
    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      logic [3:0] r;
      bit         we;
      a  = 3'($urandom % 8);
      we = 1'($urandom % 2);
      d  = 8'($urandom);
      if (a == 3'd6 && !m_tg && ($urandom % 2) == 0) d = {d[7:6], 6'h3F};
      r  = (($urandom % 12) == 0) ? 4'($urandom) : 4'h0;
      op(we, a, d, r);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule